// File: doc/BRIEF.md
# Dual-Copy Register File Operand Stage

This block is the operand-fetch stage of a 32-bit datapath with 32 general registers. It obtains two independent read ports from two single-read-port copies of the register file. Every write-back lands in both copies at the same address and on the same clock edge, so the copies always hold the same contents.

The first operand comes either from copy A or from the result bus that is being written back in the same cycle, which forwards a result one cycle early. The second operand comes either from copy B or from a 16-bit immediate, sign-extended to the data width. Both selected values are registered for the execute stage. Instruction decode and hazard detection sit outside the block and drive the address, select and write-back inputs.

Top module: `opfetch_dualrf`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `opnd_a` and `opnd_b` become zero on that edge.
- R2: Reset leaves the register contents unchanged. A register written before reset reads back the same value afterwards.
- R3: When `wr_en` is high at a rising edge, `wr_data` is stored at `wr_addr`. When `wr_en` is low, no register changes.
- R4: Reads are combinational from the stored contents. If a register is read and written in the same cycle without forwarding, the operand captures the value held before the write.
- R5: When `fwd_sel` is high, `opnd_a` captures the current `wr_data` on the next edge, whatever the state of `wr_en` and `rd_addr_a`.
- R6: When `imm_sel` is high, `opnd_b` captures `imm` sign-extended: bit 15 of `imm` is copied into bits 31 to 16.
- R7: With both selects low, `opnd_a` captures register `rd_addr_a` and `opnd_b` captures register `rd_addr_b`. If the two addresses are equal, the two operands are equal, which shows that both copies hold the same contents.
- R8: Register 0 behaves like every other register: it can be written and reads back what was written.
- R9: Both operands are registered with one cycle of latency. Each operand shows the selection made at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the operand registers |
| rd_addr_a | input | 5 | Read address for copy A |
| rd_addr_b | input | 5 | Read address for copy B |
| wr_en | input | 1 | Write-back enable |
| wr_addr | input | 5 | Write-back address, applied to both copies |
| wr_data | input | 32 | Write-back value, also the forwarding result bus |
| fwd_sel | input | 1 | Selects the result bus instead of copy A for operand A |
| imm_sel | input | 1 | Selects the sign-extended immediate instead of copy B for operand B |
| imm | input | 16 | Immediate value |
| opnd_a | output | 32 | Registered operand A |
| opnd_b | output | 32 | Registered operand B |

## Verification
The assertions check four things on every cycle. Reset zeroes both operands. The forwarded result bus reaches operand A one cycle later. The sign-extended immediate reaches operand B one cycle later. Equal read addresses with both selects low always give equal operands, so any divergence between the copies shows at once. Only the bench's scenarios can show the rest. These are that stored values survive reset, that a write with the enable low changes nothing, that a same-cycle read returns the old value, and that every address, register 0 included, holds the data written to it. The bench covers these with full sweeps over all addresses and all read-address pairs.

// File: rtl/opfetch_dualrf.sv
module opfetch_dualrf #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 32,
  parameter int IMM_W  = 16,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr_a,
  input  logic [AW-1:0]     rd_addr_b,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fwd_sel,
  input  logic              imm_sel,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  logic [DATA_W-1:0] bank_a [NREGS];
  logic [DATA_W-1:0] bank_b [NREGS];
  logic [DATA_W-1:0] imm_ext, sel_a, sel_b;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      bank_a[wr_addr] <= wr_data;
      bank_b[wr_addr] <= wr_data;
    end
  end

  assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign sel_a   = fwd_sel ? wr_data : bank_a[rd_addr_a];
  assign sel_b   = imm_sel ? imm_ext : bank_b[rd_addr_b];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opnd_a <= '0;
      opnd_b <= '0;
    end else begin
      opnd_a <= sel_a;
      opnd_b <= sel_b;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (opnd_a == '0 && opnd_b == '0));

  // R5
  fwd_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel |=> opnd_a == $past(wr_data));

  // R6
  imm_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imm_sel |=> (opnd_b[IMM_W-1:0] == $past(imm) &&
                 opnd_b[DATA_W-1:IMM_W] == {(DATA_W-IMM_W){$past(imm[IMM_W-1])}}));

  // R7
  copies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_sel && !imm_sel && rd_addr_a == rd_addr_b) |=> opnd_a == opnd_b);

endmodule

// File: tb/opfetch_dualrf_tb.sv
`timescale 1ns/1ps
module opfetch_dualrf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic        wr_en = 1'b0, fwd_sel = 1'b0, imm_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [15:0] imm = '0;
  logic [31:0] opnd_a, opnd_b;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];

  always #2.5 clk = ~clk;

  opfetch_dualrf u_dut (
    .clk(clk), .rst_n(rst_n), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .fwd_sel(fwd_sel),
    .imm_sel(imm_sel), .imm(imm), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] pat(input int i, input int k);
    return 32'((i + 1) * 32'h9E3779B9 + k * 32'h01000193);
  endfunction

  function automatic logic [31:0] sext(input logic [15:0] v);
    return (v >= 16'd32768) ? 32'(int'(v) - 65536) : 32'(int'(v));
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step(); step();
    chk("R1 reset opnd_a", opnd_a, 32'h0);
    chk("R1 reset opnd_b", opnd_b, 32'h0);
    rst_n = 1'b1;

    // R3 R8: fill every register, register 0 included
    for (int i = 0; i < 32; i++) begin
      wr_en = 1'b1; wr_addr = 5'(i); wr_data = pat(i, 0);
      model[i] = pat(i, 0);
      step();
    end
    wr_en = 1'b0;

    // R7 R9: all read-address pairs
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        rd_addr_a = 5'(a); rd_addr_b = 5'(b);
        step();
        chk("R7 opnd_a read", opnd_a, model[a]);
        chk("R7 opnd_b read", opnd_b, model[b]);
        if (a == b) chk("R7 copies equal", opnd_a, opnd_b);
      end
    end
    rd_addr_a = 5'd0; step();
    chk("R8 register 0 ordinary", opnd_a, pat(0, 0));

    // R4 R5: write while reading the same address, with and without forwarding
    for (int i = 0; i < 32; i++) begin
      wr_en = 1'b1; wr_addr = 5'(i); wr_data = pat(i, 1);
      rd_addr_a = 5'(i); rd_addr_b = 5'(i);
      fwd_sel = (i % 2 == 1);
      step();
      if (i % 2 == 1) chk("R5 forward new value", opnd_a, pat(i, 1));
      else            chk("R4 old value on same-cycle read", opnd_a, model[i]);
      chk("R4 copy B old value", opnd_b, model[i]);
      model[i] = pat(i, 1);
    end
    wr_en = 1'b0; fwd_sel = 1'b0;
    rd_addr_a = 5'd7; rd_addr_b = 5'd7; step();
    chk("R3 write landed A", opnd_a, model[7]);
    chk("R3 write landed B", opnd_b, model[7]);

    // R3: disabled writes change nothing
    for (int i = 0; i < 32; i++) begin
      wr_en = 1'b0; wr_addr = 5'(i); wr_data = 32'hDEAD0000 | 32'(i);
      step();
    end
    for (int i = 0; i < 32; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(31 - i);
      step();
      chk("R3 no write when disabled A", opnd_a, model[i]);
      chk("R3 no write when disabled B", opnd_b, model[31 - i]);
    end

    // R5: forwarding with write disabled
    fwd_sel = 1'b1; wr_en = 1'b0; wr_data = 32'h12345678; rd_addr_a = 5'd3;
    step();
    chk("R5 forward without write", opnd_a, 32'h12345678);
    fwd_sel = 1'b0; step();
    chk("R5 no write from forward", opnd_a, model[3]);

    // R6: immediate sweep including boundaries
    imm_sel = 1'b1;
    for (int v = 0; v < 65536; v += 257) begin
      imm = 16'(v); step();
      chk("R6 immediate sign extension", opnd_b, sext(16'(v)));
    end
    imm = 16'h7FFF; step(); chk("R6 imm 7fff", opnd_b, 32'h00007FFF);
    imm = 16'h8000; step(); chk("R6 imm 8000", opnd_b, 32'hFFFF8000);
    imm = 16'hFFFF; step(); chk("R6 imm ffff", opnd_b, 32'hFFFFFFFF);
    imm_sel = 1'b0;

    // R1 R2: reset mid-run keeps contents
    rst_n = 1'b0; rd_addr_a = 5'd9; rd_addr_b = 5'd20;
    step();
    chk("R1 reset opnd_a mid-run", opnd_a, 32'h0);
    chk("R1 reset opnd_b mid-run", opnd_b, 32'h0);
    rst_n = 1'b1;
    step();
    chk("R2 contents kept A", opnd_a, model[9]);
    chk("R2 contents kept B", opnd_b, model[20]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule